// File: doc/BRIEF.md
# Conditional Carry Increment Adder

This block adds two unsigned 8-bit operands in a single combinational path and returns an 8-bit sum with a carry-out. The operand width is split into 4-bit segments. Each segment is summed by its own ripple-carry adder, and every one of those adders has its carry-in held at zero. The lowest segment drives the low sum bits directly. Each higher segment is summed at the same time as the others, without waiting for the carry from below.

Each higher segment's raw sum then goes through a chain of half adders. The chain adds the carry that leaves the segment below. That carry is the OR of the lower segment's own ripple carry and the carry that leaves its incrementer. So the wide carry chain is reduced to one short increment per segment.

The block has no clock and no state. It is meant to sit inside a datapath stage wherever a small, regular adder is wanted and a duplicated adder with a select multiplexer would cost too much area.

Top module: `carry_incr_adder`

## Requirements
- R1: For every pair of operands, {carryOut, sumOut} equals the 9-bit arithmetic sum opA + opB.
- R2: sumOut[3:0] equals (opA[3:0] + opB[3:0]) mod 16 and does not depend on opA[7:4] or opB[7:4].
- R3: sumOut[7:4] equals (opA[7:4] + opB[7:4] + k) mod 16, where k is the carry out of the low segment, that is bit 4 of opA[3:0] + opB[3:0].
- R4: carryOut is 1 exactly when the upper segment's raw sum overflows, or when the increment of that raw sum by k overflows. These two carries are never both 1.
- R5: The overall carry-in is fixed at 0, so opA = opB = 0 gives sumOut = 0 and carryOut = 0.
- R6: When the upper raw sum is 4'b1111 and k = 1, the incrementer wraps the upper sum bits to 4'b0000 and carryOut is 1. For example, 8'hF8 + 8'h08 gives sumOut = 8'h00 and carryOut = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 8 | First unsigned operand |
| opB | input | 8 | Second unsigned operand |
| sumOut | output | 8 | Sum modulo 256 |
| carryOut | output | 1 | Carry out of bit 7 |

## Verification
The hardest case to reach from the ports is the one where the incrementer itself overflows. This needs the upper operand nibbles to sum to exactly fifteen while the lower nibbles also produce a carry. It is the only path by which a carry reaches carryOut through the half-adder chain rather than through the upper ripple adder. The sweep drives every one of the 65,536 operand pairs, so every such combination is reached. A directed pair then targets the wrap case by name, and another targets the all-zero input. Checking the low and high sum nibbles separately for each pair shows whether an error comes from the direct low path or from the increment path.

// File: rtl/cia_pkg.sv
package cia_pkg;
  localparam int unsigned CIA_WIDTH = 8;
  localparam int unsigned CIA_SEG   = 4;

  // Carry strobes exchanged between a segment's ripple adder and its incrementer
  typedef struct packed {
    logic partCarry;  // raw overflow of the segment ripple adder
    logic incCarry;   // overflow of the half-adder increment chain
  } segCarry_t;
endpackage

// File: rtl/cia_ripple.sv
module cia_ripple #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] addA,
  input  logic [W-1:0] addB,
  input  logic         cinBit,
  output logic [W-1:0] sumBits,
  output logic         coutBit
);
  logic [W:0] chain;

  assign chain[0] = cinBit;

  for (genvar i = 0; i < W; i++) begin : g_fa
    always_comb begin
      sumBits[i]  = addA[i] ^ addB[i] ^ chain[i];
      chain[i+1]  = (addA[i] & addB[i]) | (chain[i] & (addA[i] ^ addB[i]));
    end
  end

  assign coutBit = chain[W];

  // R1: the segment adder produces the arithmetic sum of its inputs
  always_comb begin
    if (!$isunknown({addA, addB, cinBit}))
      a_r1_segment_sum: assert ({coutBit, sumBits} ==
                                ({1'b0, addA} + {1'b0, addB} + {{W{1'b0}}, cinBit}))
        else $error("segment ripple sum mismatch");
  end
endmodule

// File: rtl/cia_increment.sv
module cia_increment #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] rawBits,
  input  logic         incBit,
  output logic [W-1:0] resBits,
  output logic         ovfBit
);
  logic [W:0] ripple;

  assign ripple[0] = incBit;

  for (genvar i = 0; i < W; i++) begin : g_ha
    always_comb begin
      resBits[i]  = rawBits[i] ^ ripple[i];
      ripple[i+1] = rawBits[i] & ripple[i];
    end
  end

  assign ovfBit = ripple[W];

  // R3: the half-adder chain adds exactly the increment bit
  always_comb begin
    if (!$isunknown({rawBits, incBit}))
      a_r3_increment: assert ({ovfBit, resBits} == ({1'b0, rawBits} + {{W{1'b0}}, incBit}))
        else $error("increment chain mismatch");
  end

  // R6: overflow of the chain only ever happens from an all-ones raw value
  always_comb begin
    if (!$isunknown({rawBits, incBit}))
      a_r6_wrap_only_all_ones: assert (!ovfBit || (&rawBits && incBit))
        else $error("increment overflow from non all-ones value");
  end
endmodule

// File: rtl/carry_incr_adder.sv
module carry_incr_adder
  import cia_pkg::*;
#(
  parameter int unsigned WIDTH = CIA_WIDTH,
  parameter int unsigned SEG   = CIA_SEG
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  localparam int unsigned NSEG = WIDTH / SEG;

  logic [NSEG-1:0] segOut;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    if (s == 0) begin : g_low
      // R5: lowest segment runs with its carry-in held at zero
      cia_ripple #(.W(SEG)) u_low (
        .addA    (opA[SEG-1:0]),
        .addB    (opB[SEG-1:0]),
        .cinBit  (1'b0),
        .sumBits (sumOut[SEG-1:0]),
        .coutBit (segOut[0])
      );
    end else begin : g_up
      logic [SEG-1:0] rawSum;
      segCarry_t      strobes;

      cia_ripple #(.W(SEG)) u_raw (
        .addA    (opA[s*SEG +: SEG]),
        .addB    (opB[s*SEG +: SEG]),
        .cinBit  (1'b0),
        .sumBits (rawSum),
        .coutBit (strobes.partCarry)
      );

      cia_increment #(.W(SEG)) u_inc (
        .rawBits (rawSum),
        .incBit  (segOut[s-1]),
        .resBits (sumOut[s*SEG +: SEG]),
        .ovfBit  (strobes.incCarry)
      );

      assign segOut[s] = strobes.partCarry | strobes.incCarry;

      // R4: raw overflow and increment overflow are mutually exclusive
      always_comb begin
        if (!$isunknown(strobes))
          a_r4_carry_exclusive: assert (!(strobes.partCarry && strobes.incCarry))
            else $error("both segment carries asserted");
      end
    end
  end

  assign carryOut = segOut[NSEG-1];

  // R1: full result matches the arithmetic sum
  always_comb begin
    if (!$isunknown({opA, opB}))
      a_r1_total_sum: assert ({carryOut, sumOut} == ({1'b0, opA} + {1'b0, opB}))
        else $error("adder total mismatch");
  end
endmodule

// File: tb/carry_incr_adder_bench.sv
module carry_incr_adder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] opA = 8'h00;
  logic [7:0] opB = 8'h00;
  logic [7:0] sumOut;
  logic       carryOut;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit finished = 1'b0;

  carry_incr_adder u_carry_incr_adder (
    .opA      (opA),
    .opB      (opB),
    .sumOut   (sumOut),
    .carryOut (carryOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s a=%02h b=%02h actual=%0h expected=%0h", req, opA, opB, act, exp);
    end
  endtask

  task automatic apply(input int a, input int b);
    @(posedge clk);
    opA = a[7:0];
    opB = b[7:0];
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (!rst) begin
      cycles <= cycles + 1;
      if (cycles >= WATCHDOG && !finished) begin
        bad++;
        total++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;

    // R5: zero operands, carry-in held at zero
    apply(0, 0);
    check("R5 sum", sumOut, 0);
    check("R5 carry", carryOut, 0);

    // R6: upper raw sum 1111 incremented by low carry wraps
    apply(8'hF8, 8'h08);
    check("R6 sum", sumOut, 0);
    check("R6 carry", carryOut, 1);
    apply(8'h7F, 8'h81);
    check("R6 sum2", sumOut, 0);
    check("R6 carry2", carryOut, 1);

    // R2: low nibble unaffected by upper operand bits
    apply(8'h05, 8'h06);
    check("R2 low", sumOut[3:0], 4'hB);
    apply(8'hA5, 8'h36);
    check("R2 low upper-changed", sumOut[3:0], 4'hB);

    // Exhaustive sweep: R1, R2, R3, R4
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        int full, k, upExp, upRaw;
        apply(a, b);
        full  = a + b;
        k     = ((a % 16) + (b % 16)) / 16;
        upRaw = (a / 16) + (b / 16);
        upExp = (upRaw + k) % 16;
        check("R1", {23'd0, carryOut, sumOut}, full);
        check("R2", sumOut[3:0], (a + b) % 16);
        check("R3", sumOut[7:4], upExp);
        check("R4", carryOut, (upRaw >= 16 || (upRaw % 16 == 15 && k == 1)) ? 1 : 0);
      end
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule